// File: doc/BRIEF.md
# Half-Duplex Absolute Encoder Poller

This block keeps a running 24-bit angle reading from an absolute rotary encoder that shares one half-duplex differential pair with its host. On a fixed schedule it takes the line, sends a single 16-bit request word, and releases the line. It then listens for three 16-bit reply words: a status word, the low 16 position bits, and a combined word that carries the top 8 position bits and an 8-bit check byte. The transceiver itself sits outside the block. The block sees only a transmit data pin, a drive-enable pin and the received data pin.

The reply is checked before it is used. The check byte must match a CRC-8 whose polynomial is a parameter, and every stop bit must be high. When the reply passes, the block publishes the status, the merged position and a free-running cycle timestamp, and pulses a valid strobe for one cycle. A reply that fails, or one that does not arrive before a deadline, bumps a saturating error counter and leaves the published values alone. After either outcome the block waits a programmable pause and polls again.

Top module: `enc_poller`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `line_tx` is 1, `line_te` is 0, `rep_valid` is 0 and `err_count` is 0.
- R2: Every serial frame is one low start bit, then 16 data bits LSB first, then one high stop bit, each lasting `CLK_PER_BIT` cycles. The request word is the `CMD_WORD` parameter, which packs check bits in [15:13], command code in [12:8], address in [7:5], frame code in [4:3] and sync code in [2:0].
- R3: `line_te` rises exactly `CLK_PER_BIT` cycles before the request start bit begins. It falls exactly `19*CLK_PER_BIT+1` cycles after the start bit begins, which is one bit time after the transmitter signals completion.
- R4: The receiver is disabled while `line_te` is high, so the block's own transmitted frame, echoed onto `line_rx`, is never taken as reply data. Any pending receive state is discarded when the receiver is armed, so the first reply word always lands in the status slot.
- R5: Reply words are assigned in arrival order: word 1 is status, word 2 is position[15:0], and word 3 carries position[23:16] in bits [7:0] and the check byte in bits [15:8]. `rep_pos` is {word3[7:0], word2}.
- R6: After an accepted reply, `rep_valid` is high for exactly one cycle. `rep_time` is a free-running cycle count sampled when the third word completes, so two successive `rep_time` values differ by exactly the number of cycles between their strobes.
- R7: The check byte must equal a CRC-8 computed MSB first over status, then position[15:0], then position[23:16] (40 bits), with initial value 0 and the `CRC_POLY` feedback taps (x^8 implied). On a mismatch, `rep_valid` stays low and `err_count` rises by one.
- R8: A low stop bit on any reply word suppresses `rep_valid` and increments `err_count`.
- R9: If three words are not received within `REPLY_TIMEOUT` cycles of arming, `err_count` increments, `rep_valid` stays low and polling resumes.
- R10: `err_count` saturates at 2^`ERR_W`-1. Further errors leave it there, and a later good reply is still accepted.
- R11: The next `line_te` rise comes exactly `PAUSE_CYCLES` cycles after the cycle in which a transaction ends.
- R12: `rep_status`, `rep_pos` and `rep_time` change only together with `rep_valid`. A rejected reply leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_rx | input | 1 | Received serial data from the transceiver |
| line_tx | output | 1 | Transmit serial data, idle high |
| line_te | output | 1 | Transceiver drive enable |
| rep_valid | output | 1 | One-cycle strobe for an accepted reply |
| rep_status | output | 16 | Status word of the last accepted reply |
| rep_pos | output | 24 | Merged position of the last accepted reply |
| rep_time | output | TS_W | Timestamp of the last accepted reply |
| err_count | output | ERR_W | Saturating count of rejected or missing replies |

## Verification
The bench timestamps every `line_te` and `line_tx` edge on the falling clock edge, using its own cycle counter. From these it checks the lead of exactly one bit time, the release at 19 bit times plus one cycle, and the `PAUSE_CYCLES` gap from a valid strobe to the next drive-enable rise. It decodes the request at mid-bit and compares the result with `CMD_WORD`. The reply frames are driven on falling edges. The valid strobe is due a few cycles after the middle of the third stop bit, so the bench waits two bit times past the end of that frame before it compares outputs and counts strobes. That window is long enough to catch the strobe and short enough that the next poll has not started. Timestamps are compared as differences between successive strobes, which makes the check independent of the fixed capture latency.

// File: rtl/enc_poll_pkg.sv
package enc_poll_pkg;

  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    PL_PAUSE = 3'd0,
    PL_LEAD  = 3'd1,
    PL_SEND  = 3'd2,
    PL_TAIL  = 3'd3,
    PL_RECV  = 3'd4
  } poll_state_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/enc_crc8.sv
module enc_crc8 #(
  parameter int unsigned DATA_W = 40,
  parameter logic [7:0]  POLY   = 8'h07
) (
  input  logic [DATA_W-1:0] data,
  output logic [7:0]        crc
);
  always_comb begin
    logic [7:0] acc;
    logic       fb;
    acc = 8'h00;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = acc[7] ^ data[i];
      acc = {acc[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
    end
    crc = acc;
  end
endmodule

// File: rtl/enc_ser_tx.sv
module enc_ser_tx #(
  parameter int unsigned CLK_PER_BIT = 72,
  parameter int unsigned W           = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] data,
  output logic         line,
  output logic         busy,
  output logic         done
);
  localparam int unsigned NBITS = W + 2;
  localparam int unsigned CW    = $clog2(CLK_PER_BIT);
  localparam int unsigned BW    = $clog2(NBITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_PER_BIT - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

  logic [NBITS-1:0] frame_q, frame_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    frame_d = frame_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        frame_d = {1'b1, data, 1'b0};
        cnt_d   = '0;
        bit_d   = '0;
        busy_d  = 1'b1;
      end
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
      if (bit_q == BIT_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        bit_d   = bit_q + 1'b1;
        frame_d = {1'b1, frame_q[NBITS-1:1]};
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      cnt_q   <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign line = busy_q ? frame_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;

  // R2: an accepted start request drives the start bit on the next cycle
  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !line));

endmodule

// File: rtl/enc_ser_rx.sv
module enc_ser_rx
  import enc_poll_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 72,
  parameter int unsigned W           = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         line,
  output logic         word_stb,
  output logic [W-1:0] word,
  output logic         frame_err
);
  localparam int unsigned CW = $clog2(CLK_PER_BIT);
  localparam int unsigned BW = $clog2(W);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(CLK_PER_BIT / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [W-1:0]  sh_q, sh_d;
  logic          stb_q, stb_d;
  logic          ferr_q, ferr_d;

  assign rx_s = sync_q[1];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    stb_d  = 1'b0;
    ferr_d = ferr_q;
    if (!en) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          cnt_d = '0;
          if (!rx_s) st_d = RX_START;
        end
        RX_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_d = '0;
            bit_d = '0;
            st_d  = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            sh_d  = {rx_s, sh_q[W-1:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q == BIT_LAST) st_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d  = '0;
            stb_d  = 1'b1;
            ferr_d = !rx_s;
            st_d   = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      stb_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      stb_q  <= stb_d;
      ferr_q <= ferr_d;
    end
  end

  assign word_stb  = stb_q;
  assign word      = sh_q;
  assign frame_err = ferr_q;

  // R4: a word is only reported while the receiver is armed
  assert_stb_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> en);

endmodule

// File: rtl/enc_poller.sv
module enc_poller
  import enc_poll_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT   = 72,
  parameter logic [15:0] CMD_WORD      = 16'h8102,
  parameter logic [7:0]  CRC_POLY      = 8'h07,
  parameter int unsigned PAUSE_CYCLES  = 180000,
  parameter int unsigned REPLY_TIMEOUT = 20000,
  parameter int unsigned ERR_W         = 8,
  parameter int unsigned TS_W          = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_rx,
  output logic            line_tx,
  output logic            line_te,
  output logic            rep_valid,
  output logic [15:0]     rep_status,
  output logic [23:0]     rep_pos,
  output logic [TS_W-1:0] rep_time,
  output logic [ERR_W-1:0] err_count
);
  localparam int unsigned CNT_MAX = max3(PAUSE_CYCLES, REPLY_TIMEOUT, CLK_PER_BIT);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(PAUSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(REPLY_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(CLK_PER_BIT - 1);
  localparam logic [ERR_W-1:0] ERR_MAX    = '1;

  poll_state_t      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       widx_q, widx_d;
  logic             ferr_q, ferr_d;
  logic [15:0]      w_stat_q, w_stat_d;
  logic [15:0]      w_plo_q, w_plo_d;
  logic             valid_q, valid_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [15:0]      o_stat_q, o_stat_d;
  logic [23:0]      o_pos_q, o_pos_d;
  logic [TS_W-1:0]  o_time_q, o_time_d;
  logic [TS_W-1:0]  ts_q;

  logic        tx_start, tx_busy, tx_done;
  logic        rx_en, rx_stb, rx_ferr;
  logic [15:0] rx_word;
  logic [7:0]  crc_calc;

  enc_ser_tx #(.CLK_PER_BIT(CLK_PER_BIT), .W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .data(CMD_WORD),
    .line(line_tx), .busy(tx_busy), .done(tx_done)
  );

  enc_ser_rx #(.CLK_PER_BIT(CLK_PER_BIT), .W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .line(line_rx),
    .word_stb(rx_stb), .word(rx_word), .frame_err(rx_ferr)
  );

  enc_crc8 #(.DATA_W(40), .POLY(CRC_POLY)) u_crc (
    .data({w_stat_q, w_plo_q, rx_word[7:0]}), .crc(crc_calc)
  );

  assign rx_en   = (st_q == PL_RECV);
  assign line_te = (st_q == PL_LEAD) || (st_q == PL_SEND) || (st_q == PL_TAIL);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    widx_d   = widx_q;
    ferr_d   = ferr_q;
    w_stat_d = w_stat_q;
    w_plo_d  = w_plo_q;
    valid_d  = 1'b0;
    err_d    = err_q;
    o_stat_d = o_stat_q;
    o_pos_d  = o_pos_q;
    o_time_d = o_time_q;
    tx_start = 1'b0;
    case (st_q)
      PL_PAUSE: begin
        if (cnt_q == PAUSE_LAST) begin
          cnt_d = '0;
          st_d  = PL_LEAD;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PL_LEAD: begin
        if (cnt_q == BIT_LAST) begin
          cnt_d    = '0;
          tx_start = 1'b1;
          st_d     = PL_SEND;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PL_SEND: begin
        cnt_d = '0;
        if (tx_done) st_d = PL_TAIL;
      end
      PL_TAIL: begin
        if (cnt_q == BIT_LAST) begin
          cnt_d  = '0;
          widx_d = '0;
          ferr_d = 1'b0;
          st_d   = PL_RECV;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        cnt_d = cnt_q + 1'b1;
        if (rx_stb) begin
          ferr_d = ferr_q | rx_ferr;
          widx_d = widx_q + 1'b1;
          if (widx_q == 2'd0) w_stat_d = rx_word;
          if (widx_q == 2'd1) w_plo_d  = rx_word;
          if (widx_q == 2'd2) begin
            cnt_d = '0;
            st_d  = PL_PAUSE;
            if (!ferr_q && !rx_ferr && (crc_calc == rx_word[15:8])) begin
              valid_d  = 1'b1;
              o_stat_d = w_stat_q;
              o_pos_d  = {rx_word[7:0], w_plo_q};
              o_time_d = ts_q;
            end else if (err_q != ERR_MAX) begin
              err_d = err_q + 1'b1;
            end
          end
        end else if (cnt_q == TMO_LAST) begin
          cnt_d = '0;
          st_d  = PL_PAUSE;
          if (err_q != ERR_MAX) err_d = err_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PL_PAUSE;
      cnt_q    <= '0;
      widx_q   <= '0;
      ferr_q   <= 1'b0;
      w_stat_q <= '0;
      w_plo_q  <= '0;
      valid_q  <= 1'b0;
      err_q    <= '0;
      o_stat_q <= '0;
      o_pos_q  <= '0;
      o_time_q <= '0;
      ts_q     <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      widx_q   <= widx_d;
      ferr_q   <= ferr_d;
      w_stat_q <= w_stat_d;
      w_plo_q  <= w_plo_d;
      valid_q  <= valid_d;
      err_q    <= err_d;
      o_stat_q <= o_stat_d;
      o_pos_q  <= o_pos_d;
      o_time_q <= o_time_d;
      ts_q     <= ts_q + 1'b1;
    end
  end

  assign rep_valid  = valid_q;
  assign rep_status = o_stat_q;
  assign rep_pos    = o_pos_q;
  assign rep_time   = o_time_q;
  assign err_count  = err_q;

  // R3: the drive enable covers the whole transmitted frame
  assert_te_covers_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> line_te);

  // R3: the line is still idle when the drive enable first rises
  assert_te_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_te) |-> line_tx);

  // R4: no received word is reported while the block drives the line
  assert_rx_blanked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |-> !line_te);

  // R6: the valid strobe lasts one cycle
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |=> !rep_valid);

  // R7: an accepted reply does not count as an error
  assert_valid_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> $stable(err_count));

  // R10: the error counter holds once saturated
  assert_err_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == ERR_MAX) |=> (err_count == ERR_MAX));

  // R12: published position only moves with the strobe
  assert_pos_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_valid |-> $stable(rep_pos));

endmodule

// File: tb/enc_poller_test.sv
module enc_poller_test;
  localparam int CLK_NS = 10;
  localparam int CPB    = 8;
  localparam int PAUSE  = 200;
  localparam int TMO    = 1000;
  localparam int ERR_W  = 2;
  localparam int TS_W   = 32;
  localparam logic [15:0] CMD  = 16'h8102;
  localparam logic [7:0]  POLY = 8'h31;
  localparam int NVEC = 9;

  // {status, position, bad_crc, bad_stop, silent}
  localparam logic [42:0] VEC [NVEC] = '{
    {16'h0000, 24'h000000, 3'b000},
    {16'hA5C3, 24'h123456, 3'b000},
    {16'hFFFF, 24'hFFFFFF, 3'b000},
    {16'h1234, 24'hABCDEF, 3'b100},
    {16'h0F0F, 24'h00FF00, 3'b000},
    {16'h5555, 24'h800001, 3'b010},
    {16'h0000, 24'h000000, 3'b001},
    {16'h0001, 24'h000002, 3'b100},
    {16'h8000, 24'h7FFFFF, 3'b000}
  };

  logic clk, rst_n, line_rx, line_tx, line_te, rep_valid, enc_line;
  logic [15:0] rep_status;
  logic [23:0] rep_pos;
  logic [TS_W-1:0] rep_time;
  logic [ERR_W-1:0] err_count;

  int n_chk, n_bad, cyc;
  int nvalid, dbl, last_vcyc, prev_vcyc;
  logic [TS_W-1:0] last_ts, prev_ts;
  logic prev_v;
  bit finished;

  assign line_rx = line_te ? line_tx : enc_line;

  enc_poller #(
    .CLK_PER_BIT(CPB), .CMD_WORD(CMD), .CRC_POLY(POLY), .PAUSE_CYCLES(PAUSE),
    .REPLY_TIMEOUT(TMO), .ERR_W(ERR_W), .TS_W(TS_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .line_rx(line_rx), .line_tx(line_tx),
    .line_te(line_te), .rep_valid(rep_valid), .rep_status(rep_status),
    .rep_pos(rep_pos), .rep_time(rep_time), .err_count(err_count)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rep_valid) begin
      if (prev_v) dbl <= dbl + 1;
      prev_vcyc <= last_vcyc;
      prev_ts   <= last_ts;
      last_vcyc <= cyc;
      last_ts   <= rep_time;
      nvalid    <= nvalid + 1;
    end
    prev_v <= rst_n && rep_valid;
  end

  function automatic logic [7:0] crc_ref(input logic [39:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 39; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic send_word(input logic [15:0] w, input bit bad_stop);
    enc_line = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int b = 0; b < 16; b++) begin
      enc_line = w[b];
      repeat (CPB) @(negedge clk);
    end
    enc_line = !bad_stop;
    repeat (CPB) @(negedge clk);
    enc_line = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int t_te, t_tx, t_fall, nv_before, exp_err;
    logic [15:0] cmd_rx, st_before;
    logic [23:0] pos_before;
    logic stop_rx;
    bit prev_good;
    n_chk = 0; n_bad = 0; cyc = 0; nvalid = 0; dbl = 0;
    last_vcyc = 0; prev_vcyc = 0; last_ts = '0; prev_ts = '0; prev_v = 1'b0;
    finished = 1'b0; enc_line = 1'b1; rst_n = 1'b0; prev_good = 1'b0; exp_err = 0;
    repeat (4) @(negedge clk);
    check(line_tx == 1'b1 && line_te == 1'b0, "R1 idle line in reset", {line_te, line_tx}, 2'b01);
    check(rep_valid == 1'b0 && err_count == 0, "R1 outputs in reset", {rep_valid, err_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_te == 1'b0 && line_tx == 1'b1 && err_count == 0, "R1 after release",
          {line_te, line_tx, err_count}, 3'b010);

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] vs;
      logic [23:0] vp;
      logic bcrc, bstop, sil;
      logic [7:0] ck;
      {vs, vp, bcrc, bstop, sil} = VEC[v];
      do @(negedge clk); while (!line_te);
      t_te = cyc;
      if (prev_good)
        check(t_te - last_vcyc == PAUSE, "R11 pause after valid", t_te - last_vcyc, PAUSE);
      do @(negedge clk); while (line_tx);
      t_tx = cyc;
      check(t_tx - t_te == CPB, "R3 enable lead", t_tx - t_te, CPB);
      repeat (CPB / 2) @(negedge clk);
      for (int b = 0; b < 16; b++) begin
        repeat (CPB) @(negedge clk);
        cmd_rx[b] = line_tx;
      end
      repeat (CPB) @(negedge clk);
      stop_rx = line_tx;
      check(cmd_rx == CMD, "R2 command word", cmd_rx, CMD);
      check(stop_rx == 1'b1, "R2 stop bit", stop_rx, 1);
      do @(negedge clk); while (line_te);
      t_fall = cyc;
      check(t_fall - t_tx == 19 * CPB + 1, "R3 enable release", t_fall - t_tx, 19 * CPB + 1);
      nv_before = nvalid; st_before = rep_status; pos_before = vp;
      pos_before = rep_pos;
      if (sil) begin
        repeat (TMO + 5) @(negedge clk);
        exp_err = (exp_err == 3) ? 3 : exp_err + 1;
        check(err_count == exp_err, "R9 timeout counted", err_count, exp_err);
        check(nvalid == nv_before, "R9 no strobe on timeout", nvalid - nv_before, 0);
        prev_good = 1'b0;
      end else begin
        ck = crc_ref({vs, vp[15:0], vp[23:16]});
        if (bcrc) ck = ck ^ 8'h5A;
        repeat (3 * CPB) @(negedge clk);
        send_word(vs, 1'b0);
        send_word(vp[15:0], 1'b0);
        send_word({ck, vp[23:16]}, bstop);
        repeat (CPB) @(negedge clk);
        if (bcrc || bstop) begin
          exp_err = (exp_err == 3) ? 3 : exp_err + 1;
          check(nvalid == nv_before, bcrc ? "R7 no strobe on bad crc" : "R8 no strobe on bad stop",
                nvalid - nv_before, 0);
          check(err_count == exp_err, bcrc ? "R7 error counted R10" : "R8 error counted",
                err_count, exp_err);
          check(rep_status == st_before && rep_pos == pos_before, "R12 outputs held",
                rep_pos, pos_before);
          prev_good = 1'b0;
        end else begin
          check(nvalid == nv_before + 1, "R6 one strobe", nvalid - nv_before, 1);
          check(rep_status == vs, "R5 status slot R4", rep_status, vs);
          check(rep_pos == vp, "R5 merged position", rep_pos, vp);
          check(err_count == exp_err, "R10 count after good reply", err_count, exp_err);
          if (nvalid >= 2)
            check(last_ts - prev_ts == TS_W'(last_vcyc - prev_vcyc), "R6 timestamp spacing",
                  last_ts - prev_ts, last_vcyc - prev_vcyc);
          prev_good = 1'b1;
        end
      end
    end

    check(dbl == 0, "R6 strobe width", dbl, 0);
    check(err_count == 3, "R10 saturated", err_count, 3);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(err_count == 0 && line_te == 0 && rep_valid == 0, "R1 reset clears",
          {err_count, line_te, rep_valid}, 0);
    summary();
  end
endmodule